// File: doc/BRIEF.md
# Macro Result Dispatch and Method Sender

This block is the write-back stage of a small macro processor. Each operation brings a computed 32-bit value, a destination register index and a 3-bit result-operation code. The code decides three things. The first is what goes into the destination register: the value, or the next word from an external parameter queue. The second is whether the value is loaded into the method register, which holds a target address and a step. The third is what, if anything, is sent on the outbound method-write port. After every send the target address moves forward by the step.

The block owns an eight-entry register file in which entry 0 always reads zero. It has two combinational read ports for the upstream ALU. It also owns the read index into the parameter queue and the method register. A `start` pulse begins a new macro. It clears all state, places the first parameter into register 1 and sets the parameter index to 1. If an operation needs a parameter and the queue is empty, the operation waits. While a send waits for the sink to accept it, no new operation is accepted.

Top module: `macro_result_stage`

## Requirements
- R1: A `start` pulse, or reset, clears registers 2 to 7 and the method register and sets `prm_index` to 1. After `start`, register 1 holds `start_prm`; after reset it holds 0. In both cases `snd_valid` is low.
- R2: Register 0 always reads 0 on both read ports. A write to destination 0 is discarded.
- R3: Code 0 writes the popped parameter to the destination, drops the value, sends nothing and leaves the method register unchanged.
- R4: Code 1 writes the value to the destination and sends nothing.
- R5: Code 2 writes the value and loads it into the method register: address = value[11:0], step = value[17:12]. It sends nothing.
- R6: Code 3 writes the popped parameter to the destination and sends the value at the current address.
- R7: Code 4 writes the value to the destination and sends it at the current address.
- R8: Code 5 writes the popped parameter to the destination and loads the value into the method register. It sends nothing.
- R9: Code 6 writes the value, loads it into the method register, then pops a parameter and sends it at the newly loaded address.
- R10: Code 7 writes the value, loads it into the method register, and sends value[17:12], zero-extended, at the newly loaded address.
- R11: After each send the address advances by the step, modulo 4096.
- R12: Codes 0, 3, 5 and 6 each pop exactly one parameter, and `prm_index` then rises by one. While the queue is empty such an operation is held, with `op_ready` low, and no state changes.
- R13: A send is held, with address and data stable, until `snd_ready` is high. No operation is accepted while a send is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new macro |
| start_prm | input | DW | First parameter, placed into register 1 |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation accepted this cycle |
| op_code | input | 3 | Result-operation code |
| op_dst | input | 3 | Destination register |
| op_value | input | DW | Computed value |
| prm_valid | input | 1 | Parameter queue not empty |
| prm_ready | output | 1 | Pop the parameter queue |
| prm_data | input | DW | Head of the parameter queue |
| prm_index | output | IDX_W | Index of the next parameter to pop |
| snd_valid | output | 1 | Method write pending |
| snd_ready | input | 1 | Sink accepts the method write |
| snd_addr | output | ADDR_W | Method write address |
| snd_data | output | DW | Method write data |
| rd_sel_a | input | 3 | Read port A select |
| rd_data_a | output | DW | Read port A data |
| rd_sel_b | input | 3 | Read port B select |
| rd_data_b | output | DW | Read port B data |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 12-bit address, a 6-bit step and an 8-bit index. With a 12-bit address, a step of 5 loaded at 0xFFE reaches the wrap to 0x003 in two sends. With a 6-bit step, a nonzero slice at bits 17:12 tests that code 7 picks the right field. Holding the parameter queue empty and holding `snd_ready` low for several cycles exercises both stall paths.

// File: rtl/macro_result_stage.sv
module macro_result_stage #(
  parameter int DW     = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     start_prm,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [2:0]        op_dst,
  input  logic [DW-1:0]     op_value,
  input  logic              prm_valid,
  output logic              prm_ready,
  input  logic [DW-1:0]     prm_data,
  output logic [IDX_W-1:0]  prm_index,
  output logic              snd_valid,
  input  logic              snd_ready,
  output logic [ADDR_W-1:0] snd_addr,
  output logic [DW-1:0]     snd_data,
  input  logic [2:0]        rd_sel_a,
  output logic [DW-1:0]     rd_data_a,
  input  logic [2:0]        rd_sel_b,
  output logic [DW-1:0]     rd_data_b
);
  localparam int NREG = 8;

  logic [DW-1:0]     rf [NREG];
  logic [ADDR_W-1:0] mth_addr;
  logic [INC_W-1:0]  mth_inc;

  logic fetch, sends, loads, wr_prm, accept;
  logic [DW-1:0]     wr_data, out_data;
  logic [ADDR_W-1:0] base_addr;
  logic [INC_W-1:0]  base_inc;
  logic [INC_W-1:0]  slice;

  assign fetch  = op_code inside {3'd0, 3'd3, 3'd5, 3'd6};
  assign sends  = op_code inside {3'd3, 3'd4, 3'd6, 3'd7};
  assign loads  = op_code inside {3'd2, 3'd5, 3'd6, 3'd7};
  assign wr_prm = op_code inside {3'd0, 3'd3, 3'd5};

  assign op_ready  = !start && !snd_valid && (!fetch || prm_valid);
  assign accept    = op_valid && op_ready;
  assign prm_ready = accept && fetch;

  assign slice     = op_value[ADDR_W+INC_W-1:ADDR_W];
  assign wr_data   = wr_prm ? prm_data : op_value;
  assign out_data  = (op_code == 3'd6) ? prm_data :
                     (op_code == 3'd7) ? {{(DW-INC_W){1'b0}}, slice} : op_value;
  assign base_addr = loads ? op_value[ADDR_W-1:0] : mth_addr;
  assign base_inc  = loads ? slice : mth_inc;

  assign rd_data_a = (rd_sel_a == 3'd0) ? '0 : rf[rd_sel_a];
  assign rd_data_b = (rd_sel_b == 3'd0) ? '0 : rf[rd_sel_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      mth_addr  <= '0;
      mth_inc   <= '0;
      prm_index <= IDX_W'(1);
      snd_valid <= 1'b0;
      snd_addr  <= '0;
      snd_data  <= '0;
    end else if (start) begin
      for (int i = 0; i < NREG; i++) rf[i] <= (i == 1) ? start_prm : '0;
      mth_addr  <= '0;
      mth_inc   <= '0;
      prm_index <= IDX_W'(1);
      snd_valid <= 1'b0;
    end else begin
      if (snd_valid && snd_ready) snd_valid <= 1'b0;
      if (accept) begin
        if (op_dst != 3'd0) rf[op_dst] <= wr_data;
        if (fetch) prm_index <= prm_index + 1'b1;
        mth_inc <= base_inc;
        if (sends) begin
          snd_valid <= 1'b1;
          snd_addr  <= base_addr;
          snd_data  <= out_data;
          mth_addr  <= base_addr + {{(ADDR_W-INC_W){1'b0}}, base_inc};
        end else begin
          mth_addr  <= base_addr;
        end
      end
    end
  end
endmodule

// File: rtl/macro_result_stage_chk.sv
module macro_result_stage_chk #(
  parameter int DW     = 32,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              op_valid,
  input logic              op_ready,
  input logic [2:0]        op_code,
  input logic              prm_valid,
  input logic              prm_ready,
  input logic [IDX_W-1:0]  prm_index,
  input logic              snd_valid,
  input logic              snd_ready,
  input logic [ADDR_W-1:0] snd_addr,
  input logic [DW-1:0]     snd_data,
  input logic [2:0]        rd_sel_a,
  input logic [DW-1:0]     rd_data_a
);
  logic take, quiet, loud;
  assign take  = op_valid && op_ready;
  assign quiet = op_code inside {3'd0, 3'd1, 3'd2, 3'd5};
  assign loud  = !quiet;

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (prm_index == IDX_W'(1)) && !snd_valid);

  a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == 3'd0) |-> (rd_data_a == '0));

  a_r3_no_send: assert property (@(posedge clk) disable iff (!rst_n)
    (take && quiet) |=> !snd_valid);

  a_r7_send_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (take && loud && !start) |=> snd_valid);

  a_r12_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    prm_ready |-> prm_valid);

  a_r12_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (prm_ready && !start) |=> (prm_index == IDX_W'($past(prm_index) + 1'b1)));

  a_r13_send_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready && !start) |=> snd_valid && $stable(snd_addr) && $stable(snd_data));
endmodule

bind macro_result_stage macro_result_stage_chk #(.DW(DW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_index(prm_index),
  .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_addr(snd_addr), .snd_data(snd_data),
  .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a)
);

// File: tb/test_macro_result_stage.sv
module test_macro_result_stage;
  localparam int PER = 10;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_prm = 0;
  logic        op_valid = 0, op_ready;
  logic [2:0]  op_code = 0, op_dst = 0;
  logic [31:0] op_value = 0;
  logic        prm_valid = 0, prm_ready;
  logic [31:0] prm_data = 0;
  logic [7:0]  prm_index;
  logic        snd_valid, snd_ready = 1;
  logic [11:0] snd_addr;
  logic [31:0] snd_data;
  logic [2:0]  rd_sel_a = 0, rd_sel_b = 0;
  logic [31:0] rd_data_a, rd_data_b;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] pq[$];
  logic [43:0] exp_q[$];
  logic [31:0] m_reg [8];
  logic [11:0] m_addr;
  logic [5:0]  m_inc;
  logic [7:0]  m_idx;

  always #(PER/2) clk = ~clk;

  macro_result_stage i_macro_result_stage (
    .clk(clk), .rst_n(rst_n), .start(start), .start_prm(start_prm),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code), .op_dst(op_dst),
    .op_value(op_value), .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_data(prm_data),
    .prm_index(prm_index), .snd_valid(snd_valid), .snd_ready(snd_ready),
    .snd_addr(snd_addr), .snd_data(snd_data), .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
  );

  task automatic chk(input string req, input logic [43:0] act, input logic [43:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic upd_prm();
    prm_valid = (pq.size() != 0);
    prm_data  = (pq.size() != 0) ? pq[0] : 32'h0;
  endtask

  task automatic model_clear(input logic [31:0] r1);
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    m_reg[1] = r1; m_addr = 0; m_inc = 0; m_idx = 1;
  endtask

  task automatic model_send(input logic [31:0] d);
    exp_q.push_back({m_addr, d});
    m_addr = m_addr + {6'd0, m_inc};
  endtask

  task automatic model_op(input logic [2:0] c, input logic [2:0] d, input logic [31:0] v);
    logic [31:0] p, w;
    p = 0;
    if (c inside {0, 3, 5, 6}) begin p = pq.pop_front(); m_idx++; end
    w = (c inside {0, 3, 5}) ? p : v;
    if (d != 0) m_reg[d] = w;
    if (c inside {2, 5, 6, 7}) begin m_addr = v[11:0]; m_inc = v[17:12]; end
    case (c)
      3'd3, 3'd4: model_send(v);
      3'd6:       model_send(p);
      3'd7:       model_send({26'd0, v[17:12]});
      default: ;
    endcase
  endtask

  task automatic check_reg(input string req, input logic [2:0] r);
    rd_sel_a = r; rd_sel_b = r; #1;
    chk(req, {12'd0, rd_data_a}, {12'd0, m_reg[r]});
    chk(req, {12'd0, rd_data_b}, {12'd0, m_reg[r]});
  endtask

  task automatic do_op(input string req, input logic [2:0] c, input logic [2:0] d, input logic [31:0] v);
    op_valid = 1; op_code = c; op_dst = d; op_value = v;
    forever begin
      #1;
      if (op_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    model_op(c, d, v);
    @(negedge clk);
    op_valid = 0; upd_prm();
    check_reg(req, d);
  endtask

  task automatic do_start(input logic [31:0] v);
    @(negedge clk);
    start = 1; start_prm = v;
    @(posedge clk);
    model_clear(v);
    @(negedge clk);
    start = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R11 drain", 44'(exp_q.size()), 44'd0);
  endtask

  initial begin
    forever begin
      @(negedge clk); #3;
      if (snd_valid && snd_ready) begin
        if (exp_q.size() == 0) chk("R3 unexpected send", {snd_addr, snd_data}, 44'h0);
        else chk("R6-send R11", {snd_addr, snd_data}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(PER * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    model_clear(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset snd_valid", 44'(snd_valid), 44'd0);
    chk("R1 reset index", 44'(prm_index), 44'd1);
    for (int r = 0; r < 8; r++) check_reg("R1 reset regs", 3'(r));

    do_start(32'hA5A5_0001);
    check_reg("R1 start r1", 3'd1);
    chk("R1 start index", 44'(prm_index), 44'd1);

    do_op("R4 move", 3'd1, 3'd3, 32'h1234_5678);
    do_op("R2 r0 discard", 3'd1, 3'd0, 32'hFFFF_FFFF);

    pq.push_back(32'h0000_1111); upd_prm();
    do_op("R3 fetch ignore", 3'd0, 3'd2, 32'hDEAD_0000);
    chk("R12 index after fetch", 44'(prm_index), 44'(m_idx));
    chk("R3 no send", 44'(snd_valid), 44'd0);

    do_op("R5 load method", 3'd2, 3'd4, 32'h0000_3010);
    chk("R5 no send", 44'(snd_valid), 44'd0);
    do_op("R7 move send", 3'd4, 3'd5, 32'h0000_DEAD);
    pq.push_back(32'h0000_2222); upd_prm();
    do_op("R6 fetch send", 3'd3, 3'd6, 32'h0000_BEEF);
    drain();

    do_op("R11 wrap load", 3'd2, 3'd1, 32'h0000_5FFE);
    do_op("R11 wrap send a", 3'd4, 3'd1, 32'h0000_0AAA);
    do_op("R11 wrap send b", 3'd4, 3'd1, 32'h0000_0BBB);
    drain();

    pq.push_back(32'h0000_3333); upd_prm();
    do_op("R8 fetch load", 3'd5, 3'd7, 32'h0002_1100);
    do_op("R8 send after load", 3'd4, 3'd2, 32'h0000_0C0C);
    do_op("R8 step second", 3'd4, 3'd2, 32'h0000_0D0D);
    drain();

    pq.push_back(32'h0000_4444); upd_prm();
    do_op("R9 load send param", 3'd6, 3'd3, 32'h0000_2200);
    do_op("R9 following send", 3'd4, 3'd3, 32'h0000_0E0E);
    do_op("R10 slice send", 3'd7, 3'd2, 32'hFF00_A345);
    do_op("R10 following send", 3'd4, 3'd2, 32'h0000_0F0F);
    drain();
    chk("R12 index", 44'(prm_index), 44'(m_idx));

    // R12: stall on empty queue
    @(negedge clk);
    op_valid = 1; op_code = 3'd0; op_dst = 3'd5; op_value = 32'h0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_reg("R12 stall reg", 3'd5);
      chk("R12 stall ready", {42'd0, op_ready, prm_ready}, 44'd0);
      chk("R12 stall index", 44'(prm_index), 44'(m_idx));
    end
    pq.push_back(32'h0000_5555); upd_prm();
    #1 chk("R12 resume ready", 44'(op_ready), 44'd1);
    @(posedge clk);
    model_op(3'd0, 3'd5, 32'h0);
    @(negedge clk);
    op_valid = 0; upd_prm();
    check_reg("R12 resume reg", 3'd5);
    chk("R12 resume index", 44'(prm_index), 44'(m_idx));

    // R13: backpressure
    snd_ready = 0;
    do_op("R13 send issued", 3'd4, 3'd6, 32'h0000_7777);
    op_valid = 1; op_code = 3'd1; op_dst = 3'd6; op_value = 32'h0000_9999;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R13 held", {11'd0, snd_valid, snd_addr, snd_data}, {11'd0, 1'b1, exp_q[0]});
      chk("R13 no accept", 44'(op_ready), 44'd0);
    end
    op_valid = 0;
    check_reg("R13 reg untouched", 3'd6);
    snd_ready = 1;
    drain();

    // R1: restart clears method and registers
    do_start(32'h0000_00AB);
    for (int r = 0; r < 8; r++) check_reg("R1 restart regs", 3'(r));
    do_op("R1 restart method", 3'd4, 3'd2, 32'h0000_0001);
    do_op("R1 restart step zero", 3'd4, 3'd2, 32'h0000_0002);
    drain();

    repeat (3) @(negedge clk);
    report();
  end
endmodule